// File: doc/BRIEF.md
# Interval Timer and Event Counter

This block holds an 8-bit count register that advances in one of two ways. In timer mode it counts instruction cycles: a divide-by-32 prescaler turns the per-cycle tick into one increment every 32 cycles, so a full pass from 0 back to 0 takes 8192 cycles. In counter mode the prescaler is skipped and the register advances once for each high-to-low transition on an external event pin. The pin is first passed through a two-stage synchronizer and then an edge detector. A stop command halts counting in either mode, and the register holds its value.

Each wrap from 255 to 0 sets a timer flag, whether or not the interrupt is enabled. A test strobe reads the flag and clears it. If interrupts are enabled, the same overflow also raises an interrupt request, which stays high until it is acknowledged. A load strobe writes the count register directly and leaves the flag unchanged.

Top module: `evt_timer`

## Requirements
- R1: After reset the count is 0, the flag is 0, the interrupt request is 0, and the block is halted, so ticks do not advance the count.
- R2: In timer mode the count advances by exactly one for every 32 ticks of `cyc_tick`. Ticks before any start command have no effect.
- R3: In timer mode, starting from count 0, the flag is still 0 after 8191 ticks and is 1 after 8192 ticks, with the count back at 0.
- R4: A start-timer command clears the prescaler. After a restart, 31 ticks leave the count unchanged and the 32nd tick advances it.
- R5: In counter mode each high-to-low transition of `evt_pin` advances the count by one. Rising transitions and `cyc_tick` have no effect in this mode.
- R6: After a stop command, neither ticks nor pin events change the count.
- R7: A wrap from 255 to 0 sets `tmr_flag` even when `irq_en` is 0. In that case `irq_req` stays 0.
- R8: A `flag_test` strobe clears `tmr_flag` on the next cycle. If an overflow occurs in the same cycle as the strobe, the flag remains set.
- R9: When `irq_en` is 1, an overflow raises `irq_req`. The request stays high until an `irq_ack` strobe clears it.
- R10: A `ld_en` strobe writes `ld_data` into the count on the next cycle. The load takes priority over an increment in that cycle and leaves `tmr_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_tick | input | 1 | One pulse per instruction cycle |
| evt_pin | input | 1 | External event input (asynchronous, idle high) |
| cmd_start_tmr | input | 1 | Select timer mode and clear the prescaler |
| cmd_start_cnt | input | 1 | Select event counter mode |
| cmd_stop | input | 1 | Halt counting (highest priority of the three commands) |
| ld_en | input | 1 | Load strobe for the count register |
| ld_data | input | 8 | Value to load into the count register |
| flag_test | input | 1 | Test strobe that clears the flag |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge |
| count | output | 8 | Current count value |
| tmr_flag | output | 1 | Overflow flag |
| irq_req | output | 1 | Interrupt request |

## Verification
A prescaler phase that is off by even one tick shows up as an early or late step of `count`. In timer mode this becomes visible within 32 ticks of a start, because the bench samples the count at tick 31 and at tick 32. An extra or lost increment, or a wrong wrap condition, changes `tmr_flag` on the cycle right after the wrong edge, and the 8192-tick sweep makes that error show. Faults in the flag and interrupt priority, such as a clear beating a set or an acknowledge that is ignored, are visible one cycle after the colliding strobes.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  typedef enum logic [1:0] {
    TC_IDLE  = 2'd0,
    TC_TIMER = 2'd1,
    TC_COUNT = 2'd2
  } tc_mode_e;

  // Increment with carry out: {carry, sum}
  function automatic logic [8:0] tc_bump(input logic [7:0] v);
    return {1'b0, v} + 9'd1;
  endfunction

  // Prescaler terminal test
  function automatic logic pre_last(input logic [7:0] v, input int unsigned div);
    return (32'(v) == div - 1);
  endfunction

endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= pin;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES-1];

  assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/tc_prescaler.sv
module tc_prescaler
  import evt_timer_pkg::*;
#(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [PW-1:0] phase;
  logic          last;

  assign last = pre_last(8'(phase), DIV);
  assign done = run & tick & last;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          phase <= '0;
    else if (clear)      phase <= '0;
    else if (run & tick) phase <= last ? '0 : phase + 1'b1;
endmodule

// File: rtl/tc_core.sv
module tc_core
  import evt_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_tmr,
  input  logic       go_cnt,
  input  logic       halt,
  input  logic       pre_done,
  input  logic       evt_fall,
  input  logic       ld_en,
  input  logic [7:0] ld_data,
  input  logic       flag_test,
  input  logic       irq_en,
  input  logic       irq_ack,
  output tc_mode_e   mode,
  output logic       inc,
  output logic       ovf,
  output logic [7:0] count,
  output logic       flag,
  output logic       irq
);
  logic [8:0] nxt;

  assign nxt = tc_bump(count);
  assign inc = ((mode == TC_TIMER) & pre_done) | ((mode == TC_COUNT) & evt_fall);
  assign ovf = inc & nxt[8] & ~ld_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      mode <= TC_IDLE;
    else if (halt)   mode <= TC_IDLE;
    else if (go_tmr) mode <= TC_TIMER;
    else if (go_cnt) mode <= TC_COUNT;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     count <= '0;
    else if (ld_en) count <= ld_data;
    else if (inc)   count <= nxt[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         flag <= 1'b0;
    else if (ovf)       flag <= 1'b1;
    else if (flag_test) flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             irq <= 1'b0;
    else if (ovf & irq_en)  irq <= 1'b1;
    else if (irq_ack)       irq <= 1'b0;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int PRE_DIV     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_tick,
  input  logic       evt_pin,
  input  logic       cmd_start_tmr,
  input  logic       cmd_start_cnt,
  input  logic       cmd_stop,
  input  logic       ld_en,
  input  logic [7:0] ld_data,
  input  logic       flag_test,
  input  logic       irq_en,
  input  logic       irq_ack,
  output logic [7:0] count,
  output logic       tmr_flag,
  output logic       irq_req
);
  tc_mode_e mode_w;
  logic     pre_done_w, evt_fall_w, inc_w, ovf_w, tmr_run_w, pre_clr_w;

  assign tmr_run_w = (mode_w == TC_TIMER);
  assign pre_clr_w = cmd_start_tmr & ~cmd_stop;

  evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(evt_pin), .fall(evt_fall_w)
  );

  tc_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(pre_clr_w), .run(tmr_run_w),
    .tick(cyc_tick), .done(pre_done_w)
  );

  tc_core u_core (
    .clk(clk), .rst_n(rst_n), .go_tmr(cmd_start_tmr), .go_cnt(cmd_start_cnt),
    .halt(cmd_stop), .pre_done(pre_done_w), .evt_fall(evt_fall_w),
    .ld_en(ld_en), .ld_data(ld_data), .flag_test(flag_test),
    .irq_en(irq_en), .irq_ack(irq_ack), .mode(mode_w), .inc(inc_w),
    .ovf(ovf_w), .count(count), .flag(tmr_flag), .irq(irq_req)
  );
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       inc,
  input logic       ovf,
  input logic       running,
  input logic       ld_en,
  input logic [7:0] ld_data,
  input logic       flag_test,
  input logic       irq_ack,
  input logic [7:0] count,
  input logic       tmr_flag,
  input logic       irq_req
);
  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld_en) |=> count == 8'($past(count) + 8'd1));
  // R6
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !ld_en) |=> $stable(count));
  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> tmr_flag);
  // R8
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_test && !ovf) |=> !tmr_flag);
  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> irq_req);
  // R10
  load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> count == $past(ld_data));
  // R10
  load_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !flag_test) |=> tmr_flag == $past(tmr_flag));
endmodule

bind evt_timer evt_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .inc(inc_w), .ovf(ovf_w),
  .running(mode_w != evt_timer_pkg::TC_IDLE), .ld_en(ld_en), .ld_data(ld_data),
  .flag_test(flag_test), .irq_ack(irq_ack), .count(count),
  .tmr_flag(tmr_flag), .irq_req(irq_req)
);

// File: tb/evt_timer_tb.sv
`timescale 1ns/1ps
module evt_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_tick = 1'b0, evt_pin = 1'b1;
  logic       cmd_start_tmr = 1'b0, cmd_start_cnt = 1'b0, cmd_stop = 1'b0;
  logic       ld_en = 1'b0, flag_test = 1'b0, irq_en = 1'b0, irq_ack = 1'b0;
  logic [7:0] ld_data = '0;
  logic [7:0] count;
  logic       tmr_flag, irq_req;
  int         n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  evt_timer u_dut (.*);

  // {flag, load value, falling events, expected count}
  localparam logic [24:0] VEC [6] = '{
    {1'b0, 8'd10,  8'd5,  8'd15},
    {1'b0, 8'd250, 8'd5,  8'd255},
    {1'b1, 8'd254, 8'd3,  8'd1},
    {1'b1, 8'd255, 8'd1,  8'd0},
    {1'b0, 8'd0,   8'd0,  8'd0},
    {1'b1, 8'd200, 8'd60, 8'd4}
  };

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    cyc_tick = 1'b1; step(n); cyc_tick = 1'b0;
  endtask

  task automatic load(logic [7:0] v);
    ld_data = v; ld_en = 1'b1; step(); ld_en = 1'b0;
  endtask

  task automatic cmd_tmr();  cmd_start_tmr = 1'b1; step(); cmd_start_tmr = 1'b0; endtask
  task automatic cmd_cnt();  cmd_start_cnt = 1'b1; step(); cmd_start_cnt = 1'b0; endtask
  task automatic cmd_halt(); cmd_stop = 1'b1; step(); cmd_stop = 1'b0; endtask
  task automatic clr_flag(); flag_test = 1'b1; step(); flag_test = 1'b0; endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      evt_pin = 1'b0; step(4); evt_pin = 1'b1; step(4);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    step(200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    step(3);
    // R1 reset state
    check("R1 count", count, 0);
    check("R1 flag", tmr_flag, 0);
    check("R1 irq", irq_req, 0);
    rst_n = 1'b1; step();
    ticks(40);
    check("R1 idle ticks", count, 0);

    // R5 / R7 / R10 table in counter mode
    cmd_cnt();
    for (int r = 0; r < 6; r++) begin
      clr_flag();
      load(VEC[r][23:16]);
      pulses(int'(VEC[r][15:8]));
      check($sformatf("R5 vec%0d count", r), count, VEC[r][7:0]);
      check($sformatf("R7 vec%0d flag", r), tmr_flag, VEC[r][24]);
      check($sformatf("R7 vec%0d irq off", r), irq_req, 0);
    end

    // R5 rising edges and ticks ignored in counter mode
    clr_flag(); load(8'd7);
    evt_pin = 1'b0; step(6);
    check("R5 one fall", count, 8);
    evt_pin = 1'b1; step(6);
    ticks(40);
    check("R5 rise and ticks ignored", count, 8);

    // R6 stop halts both modes
    cmd_halt();
    pulses(3); ticks(64);
    check("R6 halted", count, 8);

    // R2 timer rate
    load(8'd0); cmd_tmr();
    ticks(31);
    check("R2 tick31", count, 0);
    ticks(1);
    check("R2 tick32", count, 1);
    ticks(64);
    check("R2 tick96", count, 3);
    pulses(2);
    check("R2 pin ignored in timer", count, 3);

    // R4 prescaler cleared on restart
    ticks(20); cmd_tmr();
    ticks(31);
    check("R4 restart 31", count, 3);
    ticks(1);
    check("R4 restart 32", count, 4);

    // R3 full period
    clr_flag(); load(8'd0); cmd_tmr();
    ticks(8191);
    check("R3 flag at 8191", tmr_flag, 0);
    check("R3 count at 8191", count, 255);
    ticks(1);
    check("R3 flag at 8192", tmr_flag, 1);
    check("R3 count wrap", count, 0);

    // R8 test clears flag
    clr_flag();
    check("R8 cleared", tmr_flag, 0);

    // R10 load keeps flag set, and wins over increment
    load(8'd255); cmd_tmr();
    ticks(32);
    check("R7 flag set", tmr_flag, 1);
    load(8'd77);
    check("R10 load value", count, 77);
    check("R10 flag kept", tmr_flag, 1);
    ticks(31);
    ld_data = 8'd9; ld_en = 1'b1; cyc_tick = 1'b1; step();
    ld_en = 1'b0; cyc_tick = 1'b0;
    check("R10 load beats inc", count, 9);

    // R8 overflow and test in same cycle: set wins
    clr_flag(); load(8'd255); cmd_tmr();
    ticks(31);
    flag_test = 1'b1; cyc_tick = 1'b1; step();
    flag_test = 1'b0; cyc_tick = 1'b0;
    check("R8 set beats clear", tmr_flag, 1);

    // R9 interrupt held until acknowledged
    cmd_halt(); clr_flag(); irq_en = 1'b1;
    load(8'd255); cmd_cnt();
    pulses(1);
    check("R9 irq raised", irq_req, 1);
    irq_en = 1'b0; step(10);
    check("R9 irq held", irq_req, 1);
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
    check("R9 irq acked", irq_req, 0);
    check("R9 flag still set", tmr_flag, 1);

    finish_run();
  end
endmodule